// File: doc/BRIEF.md
# Segmented Page-Table Entry Address Generator

This block sits at the start of a hardware page-table walk for a memory scheme that combines segments with paging. Each request carries a 32-bit virtual address. The two most significant bits choose a segment, the next 18 bits are the virtual page number, and the low 12 bits are the byte offset within a 4 KB page. Segment value 0 is reserved and never mapped. Values 1, 2 and 3 stand for code, heap and stack.

Each mapped segment owns one pair of 32-bit registers. The first holds the physical address where that segment's linear page table starts. The second holds how many entries that table has. From these the block forms the physical address of the 4-byte page-table entry, which is base plus four times the page number. It reports a fault instead when the segment is unused or the page number lies past the end of the table. The walker that reads the entry from memory sits downstream.

A simple write port loads the registers one at a time. The result is registered and appears one cycle after the request, together with a valid strobe.

Top module: `seg_pte_addr_gen`

## Requirements
- R1: The virtual address is split as segment = bits [31:30], page number = bits [29:12], offset = bits [11:0]. The offset bits have no effect on any output.
- R2: For a request to segment 1, 2 or 3 whose page number is below that segment's bound, rsp_fault is 0 and rsp_addr is (base + 4 × page number) modulo 2^32.
- R3: A request to segment 0 gives rsp_fault = 1 and rsp_addr = 0, whatever the registers hold.
- R4: A request to segment 1, 2 or 3 whose page number is greater than or equal to that segment's bound gives rsp_fault = 2 and rsp_addr = 0. A page number equal to bound − 1 is translated normally.
- R5: rsp_valid is high in exactly the cycle after a cycle with req_valid high. While rsp_valid is low, rsp_addr and rsp_fault are 0. Back-to-back requests each produce their own response.
- R6: A write with cfg_we high stores cfg_data into the base register (cfg_kind = 0) or the bound register (cfg_kind = 1) of segment cfg_seg. A request in the same cycle as the write uses the old value. Requests from the next cycle onward use the new value.
- R7: A write with cfg_seg = 0 changes no register. In particular, the registers of segments 1 to 3 keep their values.
- R8: Reset clears all base and bound registers to zero and clears the outputs. After reset, every request to segment 1, 2 or 3 therefore faults with code 2 until its bound is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_seg | input | 2 | Segment whose register is written |
| cfg_kind | input | 1 | 0 selects the base register, 1 selects the bound register |
| cfg_data | input | 32 | Value to write |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address of the request |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_addr | output | 32 | Physical address of the page-table entry, 0 on a fault |
| rsp_fault | output | 2 | 0 no fault, 1 unused segment, 2 page number past bound |

## Verification
A register write and a translation request can happen in the same cycle, and can target the same segment. The bench provokes this by shrinking segment 1's bound and moving its base in the same cycles that requests to that segment are issued. It then repeats the same request in the next cycle. The behavioural model applies each write only after it has computed that cycle's expected response. So the first response must show the old base and bound, and the repeated request must show the new ones, which here turns a hit into a bound fault.

// File: rtl/seg_pte_pkg.sv
package seg_pte_pkg;

  // default geometry
  localparam int unsigned DEF_VA_W      = 32;
  localparam int unsigned DEF_SEG_W     = 2;
  localparam int unsigned DEF_OFF_W     = 12;
  localparam int unsigned DEF_REG_W     = 32;
  localparam int unsigned DEF_PTE_BYTES = 4;

  // fault encoding seen on rsp_fault
  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NOSEG = 2'd1,
    FLT_BOUND = 2'd2
  } fault_e;

endpackage

// File: rtl/seg_tbl_regs.sv
module seg_tbl_regs
  import seg_pte_pkg::*;
#(
  parameter int unsigned SEG_W = DEF_SEG_W,
  parameter int unsigned REG_W = DEF_REG_W,
  localparam int unsigned NUM_SEG = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic             wr_kind,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEG_W-1:0] rd_seg,
  output logic [REG_W-1:0] rd_base,
  output logic [REG_W-1:0] rd_bound,
  output logic             rd_mapped
);

  logic [REG_W-1:0] base_q  [NUM_SEG];
  logic [REG_W-1:0] bound_q [NUM_SEG];

  // segment 0 is reserved; a write there is dropped
  logic wr_hit;
  assign wr_hit = wr_en && (wr_seg != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SEG; s++) begin
        base_q[s]  <= '0;
        bound_q[s] <= '0;
      end
    end else if (wr_hit) begin
      if (wr_kind) bound_q[wr_seg] <= wr_data;
      else         base_q[wr_seg]  <= wr_data;
    end
  end

  assign rd_mapped = (rd_seg != '0);
  assign rd_base   = rd_mapped ? base_q[rd_seg]  : '0;
  assign rd_bound  = rd_mapped ? bound_q[rd_seg] : '0;

endmodule

// File: rtl/seg_pte_calc.sv
module seg_pte_calc
  import seg_pte_pkg::*;
#(
  parameter int unsigned VA_W      = DEF_VA_W,
  parameter int unsigned SEG_W     = DEF_SEG_W,
  parameter int unsigned OFF_W     = DEF_OFF_W,
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned PTE_BYTES = DEF_PTE_BYTES,
  localparam int unsigned VPN_W     = VA_W - SEG_W - OFF_W,
  localparam int unsigned PTE_SHIFT = $clog2(PTE_BYTES)
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic             mapped,
  input  logic [REG_W-1:0] base,
  input  logic [REG_W-1:0] bound,
  output logic             over_bound,
  output logic [REG_W-1:0] pte_addr,
  output logic [1:0]       fault
);

  // entry address: table base plus page number scaled by entry size
  function automatic logic [REG_W-1:0] entry_addr(input logic [REG_W-1:0] b,
                                                 input logic [VPN_W-1:0] v);
    return b + (REG_W'(v) << PTE_SHIFT);
  endfunction

  // page number past the table end
  function automatic logic past_end(input logic [VPN_W-1:0] v,
                                    input logic [REG_W-1:0] lim);
    return REG_W'(v) >= lim;
  endfunction

  assign over_bound = past_end(vpn, bound);

  always_comb begin
    fault    = FLT_NONE;
    pte_addr = '0;
    if (!mapped)         fault = FLT_NOSEG;
    else if (over_bound) fault = FLT_BOUND;
    else                 pte_addr = entry_addr(base, vpn);
  end

endmodule

// File: rtl/seg_pte_rsp_reg.sv
module seg_pte_rsp_reg #(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [REG_W-1:0] in_addr,
  input  logic [1:0]       in_fault,
  output logic             out_valid,
  output logic [REG_W-1:0] out_addr,
  output logic [1:0]       out_fault
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_fault <= '0;
    end else begin
      out_valid <= in_valid;
      out_addr  <= in_valid ? in_addr  : '0;
      out_fault <= in_valid ? in_fault : '0;
    end
  end

endmodule

// File: rtl/seg_pte_addr_gen.sv
module seg_pte_addr_gen
  import seg_pte_pkg::*;
#(
  parameter int unsigned VA_W      = DEF_VA_W,
  parameter int unsigned SEG_W     = DEF_SEG_W,
  parameter int unsigned OFF_W     = DEF_OFF_W,
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned PTE_BYTES = DEF_PTE_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic             cfg_kind,
  input  logic [REG_W-1:0] cfg_data,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [REG_W-1:0] rsp_addr,
  output logic [1:0]       rsp_fault
);

  localparam int unsigned VPN_W = VA_W - SEG_W - OFF_W;

  // address fields
  logic [SEG_W-1:0] req_seg;
  logic [VPN_W-1:0] req_vpn;
  assign req_seg = req_vaddr[VA_W-1 -: SEG_W];
  assign req_vpn = req_vaddr[OFF_W +: VPN_W];

  // named internal events
  logic [REG_W-1:0] sel_base;
  logic [REG_W-1:0] sel_bound;
  logic             seg_mapped;
  logic             vpn_over_bound;
  logic [REG_W-1:0] calc_addr;
  logic [1:0]       calc_fault;

  seg_tbl_regs #(
    .SEG_W(SEG_W),
    .REG_W(REG_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_seg   (cfg_seg),
    .wr_kind  (cfg_kind),
    .wr_data  (cfg_data),
    .rd_seg   (req_seg),
    .rd_base  (sel_base),
    .rd_bound (sel_bound),
    .rd_mapped(seg_mapped)
  );

  seg_pte_calc #(
    .VA_W     (VA_W),
    .SEG_W    (SEG_W),
    .OFF_W    (OFF_W),
    .REG_W    (REG_W),
    .PTE_BYTES(PTE_BYTES)
  ) u_calc (
    .vpn       (req_vpn),
    .mapped    (seg_mapped),
    .base      (sel_base),
    .bound     (sel_bound),
    .over_bound(vpn_over_bound),
    .pte_addr  (calc_addr),
    .fault     (calc_fault)
  );

  seg_pte_rsp_reg #(
    .REG_W(REG_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_addr  (calc_addr),
    .in_fault (calc_fault),
    .out_valid(rsp_valid),
    .out_addr (rsp_addr),
    .out_fault(rsp_fault)
  );

endmodule

// File: rtl/seg_pte_chk.sv
module seg_pte_chk #(
  parameter int unsigned SEG_W = 2,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic             vpn_over_bound,
  input logic             rsp_valid,
  input logic [REG_W-1:0] rsp_addr,
  input logic [1:0]       rsp_fault
);

  p_rsp_follows_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_fault == 2'd0 && rsp_addr == '0));

  p_unused_seg_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg == '0) |=> (rsp_fault == 2'd1 && rsp_addr == '0));

  p_bound_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg != '0 && vpn_over_bound) |=> (rsp_fault == 2'd2));

  p_fault_clears_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault != 2'd0) |-> (rsp_addr == '0));

  p_in_bound_translates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_seg != '0 && !vpn_over_bound) |=> (rsp_fault == 2'd0));

endmodule

bind seg_pte_addr_gen seg_pte_chk #(
  .SEG_W(SEG_W),
  .REG_W(REG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_seg       (req_seg),
  .vpn_over_bound(vpn_over_bound),
  .rsp_valid     (rsp_valid),
  .rsp_addr      (rsp_addr),
  .rsp_fault     (rsp_fault)
);

// File: tb/seg_pte_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_pte_addr_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_seg = '0;
  logic        cfg_kind = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic [1:0]  rsp_fault;

  always #2.5 clk = ~clk;

  seg_pte_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
    .cfg_kind(cfg_kind), .cfg_data(cfg_data), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_fault(rsp_fault)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_base [4];
  logic [31:0] m_bnd  [4];
  bit          e_v;
  logic [31:0] e_a;
  logic [1:0]  e_f;
  string       e_tag;

  function automatic logic [31:0] va(input int seg, input int vpn, input int off);
    return {seg[1:0], vpn[17:0], off[11:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // at a negedge: judge last cycle's response, drive this cycle, advance model
  task automatic cyc(input string tag, input bit rv, input logic [31:0] a,
                     input bit we, input logic [1:0] ws, input bit wk,
                     input logic [31:0] wd);
    chk(e_tag, "rsp_valid", {31'b0, rsp_valid}, {31'b0, e_v});
    chk(e_tag, "rsp_addr", rsp_addr, e_a);
    chk(e_tag, "rsp_fault", {30'b0, rsp_fault}, {30'b0, e_f});
    req_valid = rv; req_vaddr = a;
    cfg_we = we; cfg_seg = ws; cfg_kind = wk; cfg_data = wd;
    e_tag = tag; e_v = rv; e_a = '0; e_f = 2'd0;
    if (rv) begin
      if (a[31:30] == 2'd0) e_f = 2'd1;
      else if ({14'b0, a[29:12]} >= m_bnd[a[31:30]]) e_f = 2'd2;
      else e_a = m_base[a[31:30]] + {a[29:12], 2'b00};
    end
    if (rst_n && we && ws != 2'd0) begin
      if (wk) m_bnd[ws] = wd; else m_base[ws] = wd;
    end
    @(negedge clk);
  endtask

  task automatic req(input string tag, input logic [31:0] a);
    cyc(tag, 1'b1, a, 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  task automatic wr(input string tag, input logic [1:0] s, input bit k, input logic [31:0] d);
    cyc(tag, 1'b0, 32'h0, 1'b1, s, k, d);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 1'b0, 32'h0, 1'b0, 2'd0, 1'b0, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_bnd[i] = '0; end
    e_v = 0; e_a = '0; e_f = '0; e_tag = "R8";
    @(negedge clk);
    for (int i = 0; i < 3; i++) idle("R8");
    rst_n = 1'b1;
    // R8: registers cleared, so mapped segments fault on bound
    req("R8", va(1, 0, 0));
    req("R8", va(3, 7, 5));
    // R6: program tables
    wr("R6", 2'd1, 1'b0, 32'h0010_0000);
    wr("R6", 2'd1, 1'b1, 32'd16);
    wr("R6", 2'd2, 1'b0, 32'h0020_0000);
    wr("R6", 2'd2, 1'b1, 32'h0004_0000);
    wr("R6", 2'd3, 1'b0, 32'hFFFF_FFF0);
    wr("R6", 2'd3, 1'b1, 32'd100);
    // R2: translations, back-to-back (R5)
    req("R2", va(1, 0, 0));
    req("R2", va(1, 5, 0));
    req("R4", va(1, 15, 0));
    req("R4", va(1, 16, 0));
    req("R4", va(1, 200, 0));
    idle("R5");
    req("R2", va(2, 32'h3FFFF, 0));
    req("R1", va(2, 9, 12'hFFF));
    req("R1", va(2, 9, 12'h000));
    req("R2", va(3, 4, 0));
    req("R2", va(3, 3, 0));
    req("R4", va(3, 100, 0));
    req("R3", va(0, 0, 0));
    req("R3", va(0, 12345, 77));
    idle("R5");
    idle("R5");
    // R7: writes to segment 0 are dropped
    wr("R7", 2'd0, 1'b0, 32'hDEAD_0000);
    wr("R7", 2'd0, 1'b1, 32'd1);
    req("R7", va(1, 3, 0));
    req("R7", va(2, 3, 0));
    req("R7", va(3, 3, 0));
    req("R3", va(0, 3, 0));
    // R6: write and request in the same cycle see the old value
    cyc("R6", 1'b1, va(1, 10, 0), 1'b1, 2'd1, 1'b1, 32'd4);
    req("R6", va(1, 10, 0));
    req("R6", va(1, 3, 0));
    cyc("R6", 1'b1, va(1, 2, 0), 1'b1, 2'd1, 1'b0, 32'h0000_8000);
    req("R6", va(1, 2, 0));
    req("R2", va(2, 3, 0));
    idle("R5");
    idle("R5");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule